// File: doc/BRIEF.md
# Vector Length State Registers

This block keeps the vector-length state of a scalar core whose vector extension redirects scalar register operations across element runs. Three independent banks exist, one each for machine, supervisor and user privilege; the current privilege input picks which bank the control-register port reads and writes. Each bank holds a maximum length, a current length, a sub-vector length, source and destination element offsets, a sub-vector destination offset, and a small configuration word with a bank number and a size field.

Every write is clamped before it is stored. Lengths are written as "length minus one" and kept as true lengths, so a stored length of zero stays reachable only through reset. A packed state word gathers all of a bank's fields in one register. On a trap, the packed word of the running privilege is copied into the shadow register of the target mode (machine or supervisor). Both shadow registers can also be read and written directly through the same port. Reads are combinational from the selected bank; writes take effect at the next clock edge.

Top module: `vls_regs`

## Requirements
- R1: A write to the maximum-length register (selector 0) stores min(data+1, 64); reading selector 0 returns the stored length.
- R2: A write to the current-length register (selector 1) stores min(current maximum length, data+1); reading selector 1 returns the stored length. A later maximum-length write does not change it.
- R3: A write to the sub-vector length register (selector 2) stores the data clamped into 1..4; reading returns it.
- R4: Reading the packed word (selector 3) gives length-1 in bits 5:0, maximum-1 in bits 11:6, source offset in bits 17:12, destination offset in bits 23:18, sub-vector length-1 in bits 25:24 and the sub-vector destination offset in bits 27:26; a stored length of 0 reads as 0 in its field.
- R5: Writing the packed word decodes each field from the bit positions of R4: maximum = field+1, length = min(maximum, field+1), sub-vector length = field+1, both element offsets clamped to length-1 and the sub-vector offset clamped to sub-vector length-1.
- R6: After reset every bank has both lengths 0, sub-vector length 1, bank number 0, size 1 for machine and supervisor and size 3 for user, and both shadow registers hold 0.
- R7: The config word (selector 4) reads the bank number in bits 2:0 and the size in bits 4:3; a write keeps only those bits.
- R8: When a trap is taken, the packed word of the current privilege as it stood before that edge is copied into the machine shadow (target machine) or supervisor shadow (target supervisor); a same-cycle direct write to that shadow loses, and a same-cycle length write still lands in its bank.
- R9: The machine shadow (selector 5) and supervisor shadow (selector 6) can be written and read directly and hold their value while untouched.
- R10: Privilege code 3 selects the machine bank, 1 the supervisor bank, any other code the user bank; a write changes only the selected bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege code, selects the bank |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 3 | Register selector (0..6) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data of the selected register |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_to_m | input | 1 | Trap target: 1 machine, 0 supervisor |

## Verification
A trap snapshot and a control-register write can fall in the same clock cycle, and the bench drives both at once. In one case the user bank's current length is rewritten while a supervisor-bound trap is taken; the supervisor shadow must then hold the packed word from before the write while the bank shows the new length. In the other, a direct machine-shadow write meets a machine-bound trap, and the read-back must be the snapshot, not the written data.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [2:0] {
        SEL_MAXLEN = 3'd0,
        SEL_CURLEN = 3'd1,
        SEL_SUBLEN = 3'd2,
        SEL_PACKED = 3'd3,
        SEL_CFG    = 3'd4,
        SEL_MSHAD  = 3'd5,
        SEL_SSHAD  = 3'd6
    } csr_sel_e;

    localparam int BANK_U  = 0;
    localparam int BANK_S  = 1;
    localparam int BANK_M  = 2;
    localparam int N_BANKS = 3;

endpackage

// File: rtl/vls_bank.sv
module vls_bank
    import vls_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int LEN_W    = 6,
    parameter int SUB_W    = 2,
    parameter int SIZE_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic [LEN_W:0]   mvl_o,
    output logic [LEN_W:0]   vl_o,
    output logic [SUB_W:0]   sub_o,
    output logic [XLEN-1:0]  packed_o,
    output logic [XLEN-1:0]  cfg_o
);
    localparam int MAX_LEN = 1 << LEN_W;
    localparam int SUB_MAX = 1 << SUB_W;
    localparam int VL_LSB  = 0;
    localparam int MVL_LSB = LEN_W;
    localparam int SRC_LSB = 2 * LEN_W;
    localparam int DST_LSB = 3 * LEN_W;
    localparam int SUB_LSB = 4 * LEN_W;
    localparam int DSV_LSB = 4 * LEN_W + SUB_W;
    localparam logic [LEN_W:0] ONE_L = 1;
    localparam logic [SUB_W:0] ONE_S = 1;

    logic [LEN_W:0]   mvl_q, vl_q;
    logic [SUB_W:0]   sub_q;
    logic [LEN_W-1:0] src_q, dst_q;
    logic [SUB_W-1:0] dsv_q;
    logic [2:0]       bank_q;
    logic [1:0]       size_q;

    // field views of the write data
    logic [LEN_W-1:0] f_vl, f_mvl, f_src, f_dst;
    logic [SUB_W-1:0] f_sub, f_dsv;
    assign f_vl  = wr_data[VL_LSB  +: LEN_W];
    assign f_mvl = wr_data[MVL_LSB +: LEN_W];
    assign f_src = wr_data[SRC_LSB +: LEN_W];
    assign f_dst = wr_data[DST_LSB +: LEN_W];
    assign f_sub = wr_data[SUB_LSB +: SUB_W];
    assign f_dsv = wr_data[DSV_LSB +: SUB_W];

    // clamped next values for single-register writes
    logic [LEN_W:0] mvl_wr, vl_wr;
    logic [SUB_W:0] sub_wr;
    always_comb begin
        mvl_wr = (wr_data >= XLEN'(MAX_LEN - 1)) ? (LEN_W+1)'(MAX_LEN)
                                                 : wr_data[LEN_W:0] + ONE_L;
        vl_wr  = (wr_data >= XLEN'(mvl_q)) ? mvl_q : wr_data[LEN_W:0] + ONE_L;
        if (wr_data == '0)
            sub_wr = ONE_S;
        else if (wr_data >= XLEN'(SUB_MAX))
            sub_wr = (SUB_W+1)'(SUB_MAX);
        else
            sub_wr = wr_data[SUB_W:0];
    end

    // clamped next values for a packed-word write
    logic [LEN_W-1:0] pk_vlm1, pk_src, pk_dst;
    logic [SUB_W-1:0] pk_dsv;
    always_comb begin
        pk_vlm1 = (f_vl >= f_mvl) ? f_mvl : f_vl;
        pk_src  = (f_src > pk_vlm1) ? pk_vlm1 : f_src;
        pk_dst  = (f_dst > pk_vlm1) ? pk_vlm1 : f_dst;
        pk_dsv  = (f_dsv > f_sub) ? f_sub : f_dsv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mvl_q  <= '0;
            vl_q   <= '0;
            sub_q  <= ONE_S;
            src_q  <= '0;
            dst_q  <= '0;
            dsv_q  <= '0;
            bank_q <= '0;
            size_q <= 2'(SIZE_RST);
        end else if (wr_en) begin
            unique case (csr_sel_e'(wr_sel))
                SEL_MAXLEN: mvl_q <= mvl_wr;
                SEL_CURLEN: vl_q  <= vl_wr;
                SEL_SUBLEN: sub_q <= sub_wr;
                SEL_PACKED: begin
                    mvl_q <= {1'b0, f_mvl} + ONE_L;
                    vl_q  <= {1'b0, pk_vlm1} + ONE_L;
                    sub_q <= {1'b0, f_sub} + ONE_S;
                    src_q <= pk_src;
                    dst_q <= pk_dst;
                    dsv_q <= pk_dsv;
                end
                SEL_CFG: begin
                    bank_q <= wr_data[2:0];
                    size_q <= wr_data[4:3];
                end
                default: ;
            endcase
        end
    end

    // read views: lengths reported minus one, never below zero
    logic [LEN_W:0]   vl_dec, mvl_dec;
    logic [SUB_W:0]   sub_dec;
    always_comb begin
        vl_dec  = (vl_q  == '0) ? '0 : vl_q  - ONE_L;
        mvl_dec = (mvl_q == '0) ? '0 : mvl_q - ONE_L;
        sub_dec = (sub_q == '0) ? '0 : sub_q - ONE_S;
        packed_o = '0;
        packed_o[VL_LSB  +: LEN_W] = vl_dec[LEN_W-1:0];
        packed_o[MVL_LSB +: LEN_W] = mvl_dec[LEN_W-1:0];
        packed_o[SRC_LSB +: LEN_W] = src_q;
        packed_o[DST_LSB +: LEN_W] = dst_q;
        packed_o[SUB_LSB +: SUB_W] = sub_dec[SUB_W-1:0];
        packed_o[DSV_LSB +: SUB_W] = dsv_q;
        cfg_o = '0;
        cfg_o[2:0] = bank_q;
        cfg_o[4:3] = size_q;
    end

    assign mvl_o = mvl_q;
    assign vl_o  = vl_q;
    assign sub_o = sub_q;

endmodule

// File: rtl/vls_shadow.sv
module vls_shadow #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic            trap_to_m,
    input  logic [XLEN-1:0] snap_word,
    input  logic            wr_m,
    input  logic            wr_s,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] mshad_o,
    output logic [XLEN-1:0] sshad_o
);
    logic [XLEN-1:0] mshad_q, sshad_q;

    // a trap snapshot takes precedence over a direct write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mshad_q <= '0;
            sshad_q <= '0;
        end else begin
            if (trap_valid && trap_to_m)
                mshad_q <= snap_word;
            else if (wr_m)
                mshad_q <= wr_data;
            if (trap_valid && !trap_to_m)
                sshad_q <= snap_word;
            else if (wr_s)
                sshad_q <= wr_data;
        end
    end

    assign mshad_o = mshad_q;
    assign sshad_o = sshad_q;

endmodule

// File: rtl/vls_regs.sv
module vls_regs
    import vls_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int LEN_W = 6,
    parameter int SUB_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      priv_i,
    input  logic            csr_we,
    input  logic [2:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            trap_valid,
    input  logic            trap_to_m
);
    logic [LEN_W:0]   b_mvl    [N_BANKS];
    logic [LEN_W:0]   b_vl     [N_BANKS];
    logic [SUB_W:0]   b_sub    [N_BANKS];
    logic [XLEN-1:0]  b_packed [N_BANKS];
    logic [XLEN-1:0]  b_cfg    [N_BANKS];
    logic [1:0]       cur_idx;

    always_comb begin
        unique case (priv_i)
            2'b11:   cur_idx = 2'(BANK_M);
            2'b01:   cur_idx = 2'(BANK_S);
            default: cur_idx = 2'(BANK_U);
        endcase
    end

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        vls_bank #(
            .XLEN    (XLEN),
            .LEN_W   (LEN_W),
            .SUB_W   (SUB_W),
            .SIZE_RST((g == BANK_U) ? 3 : 1)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (csr_we && (cur_idx == 2'(g))),
            .wr_sel  (csr_sel),
            .wr_data (csr_wdata),
            .mvl_o   (b_mvl[g]),
            .vl_o    (b_vl[g]),
            .sub_o   (b_sub[g]),
            .packed_o(b_packed[g]),
            .cfg_o   (b_cfg[g])
        );
    end

    logic [LEN_W:0]  cur_mvl, cur_vl;
    logic [SUB_W:0]  cur_subvl;
    logic [XLEN-1:0] cur_packed, cur_cfg, mshad_q, sshad_q;

    assign cur_mvl    = b_mvl[cur_idx];
    assign cur_vl     = b_vl[cur_idx];
    assign cur_subvl  = b_sub[cur_idx];
    assign cur_packed = b_packed[cur_idx];
    assign cur_cfg    = b_cfg[cur_idx];

    vls_shadow #(.XLEN(XLEN)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_valid(trap_valid),
        .trap_to_m (trap_to_m),
        .snap_word (cur_packed),
        .wr_m      (csr_we && (csr_sel == SEL_MSHAD)),
        .wr_s      (csr_we && (csr_sel == SEL_SSHAD)),
        .wr_data   (csr_wdata),
        .mshad_o   (mshad_q),
        .sshad_o   (sshad_q)
    );

    always_comb begin
        unique case (csr_sel_e'(csr_sel))
            SEL_MAXLEN: csr_rdata = XLEN'(cur_mvl);
            SEL_CURLEN: csr_rdata = XLEN'(cur_vl);
            SEL_SUBLEN: csr_rdata = XLEN'(cur_subvl);
            SEL_PACKED: csr_rdata = cur_packed;
            SEL_CFG:    csr_rdata = cur_cfg;
            SEL_MSHAD:  csr_rdata = mshad_q;
            SEL_SSHAD:  csr_rdata = sshad_q;
            default:    csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vls_regs_chk.sv
module vls_regs_chk
    import vls_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int LEN_W = 6,
    parameter int SUB_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      priv_i,
    input logic            csr_we,
    input logic [2:0]      csr_sel,
    input logic            trap_valid,
    input logic            trap_to_m,
    input logic [LEN_W:0]  cur_mvl,
    input logic [LEN_W:0]  cur_vl,
    input logic [SUB_W:0]  cur_subvl,
    input logic [XLEN-1:0] cur_packed,
    input logic [XLEN-1:0] mshad_q,
    input logic [XLEN-1:0] sshad_q
);
    localparam int MAX_LEN = 1 << LEN_W;
    localparam int SUB_MAX = 1 << SUB_W;
    localparam int SRC_LSB = 2 * LEN_W;
    localparam int DST_LSB = 3 * LEN_W;
    localparam int SUB_LSB = 4 * LEN_W;
    localparam int DSV_LSB = 4 * LEN_W + SUB_W;

    p_mvl_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == SEL_MAXLEN) |=>
        (($past(priv_i) != priv_i) ||
         (cur_mvl >= 1 && cur_mvl <= (LEN_W+1)'(MAX_LEN))));

    p_vl_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == SEL_CURLEN) |=>
        (($past(priv_i) != priv_i) || (cur_vl <= cur_mvl)));

    p_subvl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_subvl >= 1 && cur_subvl <= (SUB_W+1)'(SUB_MAX)));

    p_offs_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == SEL_PACKED) |=>
        (($past(priv_i) != priv_i) ||
         ((cur_packed[SRC_LSB +: LEN_W] <= cur_packed[0 +: LEN_W]) &&
          (cur_packed[DST_LSB +: LEN_W] <= cur_packed[0 +: LEN_W]) &&
          (cur_packed[DSV_LSB +: SUB_W] <= cur_packed[SUB_LSB +: SUB_W]))));

    p_msnap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_to_m) |=> (mshad_q == $past(cur_packed)));

    p_ssnap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_to_m) |=> (sshad_q == $past(cur_packed)));

    p_mshad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_valid && !(csr_we && csr_sel == SEL_MSHAD)) |=> $stable(mshad_q));

    p_sshad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_valid && !(csr_we && csr_sel == SEL_SSHAD)) |=> $stable(sshad_q));

endmodule

bind vls_regs vls_regs_chk #(
    .XLEN (XLEN),
    .LEN_W(LEN_W),
    .SUB_W(SUB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_i    (priv_i),
    .csr_we    (csr_we),
    .csr_sel   (csr_sel),
    .trap_valid(trap_valid),
    .trap_to_m (trap_to_m),
    .cur_mvl   (cur_mvl),
    .cur_vl    (cur_vl),
    .cur_subvl (cur_subvl),
    .cur_packed(cur_packed),
    .mshad_q   (mshad_q),
    .sshad_q   (sshad_q)
);

// File: tb/test_vls_regs.sv
module test_vls_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv = 2'd0;
    logic        we = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        trap_valid = 1'b0;
    logic        trap_to_m = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    vls_regs i_vls_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_i    (priv),
        .csr_we    (we),
        .csr_sel   (sel),
        .csr_wdata (wdata),
        .csr_rdata (rdata),
        .trap_valid(trap_valid),
        .trap_to_m (trap_to_m)
    );

    localparam logic [2:0] S_MAX = 3'd0, S_CUR = 3'd1, S_SUB = 3'd2,
                           S_PK = 3'd3, S_CFG = 3'd4, S_MSH = 3'd5, S_SSH = 3'd6;

    typedef struct packed {
        logic [1:0]  pv;
        logic [2:0]  ws;
        logic [31:0] wd;
        logic [2:0]  rs;
        logic [31:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, S_MAX, 32'd9,         S_MAX, 32'd10,        4'd1},  // R1
        '{2'd0, S_MAX, 32'd200,       S_MAX, 32'd64,        4'd1},  // R1 upper clamp
        '{2'd0, S_CUR, 32'd100,       S_CUR, 32'd64,        4'd2},  // R2
        '{2'd0, S_MAX, 32'd3,         S_MAX, 32'd4,         4'd1},  // R1
        '{2'd0, S_CUR, 32'd2,         S_CUR, 32'd3,         4'd2},  // R2
        '{2'd0, S_CUR, 32'd7,         S_CUR, 32'd4,         4'd2},  // R2 against max
        '{2'd0, S_SUB, 32'd0,         S_SUB, 32'd1,         4'd3},  // R3 low
        '{2'd0, S_SUB, 32'd9,         S_SUB, 32'd4,         4'd3},  // R3 high
        '{2'd0, S_SUB, 32'd3,         S_PK,  32'h020000C3,  4'd4},  // R4
        '{2'd0, S_PK,  32'h0D094245,  S_PK,  32'h05085245,  4'd5},  // R5 clamps
        '{2'd0, S_PK,  32'h0D094245,  S_CUR, 32'd6,         4'd5},  // R5
        '{2'd1, S_MAX, 32'd0,         S_MAX, 32'd1,         4'd10}, // R10 S bank
        '{2'd1, S_SUB, 32'd2,         S_CUR, 32'd0,         4'd10}, // R10
        '{2'd3, S_CFG, 32'h000000FD,  S_CFG, 32'h0000001D,  4'd7},  // R7
        '{2'd0, S_SUB, 32'd2,         S_CFG, 32'h00000018,  4'd7},  // R7 U untouched
        '{2'd3, S_SUB, 32'd4,         S_PK,  32'h03000000,  4'd4},  // R4 zero lengths
        '{2'd3, S_MSH, 32'h12345678,  S_MSH, 32'h12345678,  4'd9},  // R9
        '{2'd1, S_SSH, 32'hCAFE0001,  S_SSH, 32'hCAFE0001,  4'd9},  // R9
        '{2'd0, S_SUB, 32'd2,         S_MAX, 32'd10,        4'd10}  // R10 U kept
    };

    task automatic wr(input logic [1:0] p, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        priv = p; sel = s; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] p, input logic [2:0] s,
                          input logic [31:0] ex, input string tag);
        priv = p; sel = s;
        #1;
        checks++;
        if (rdata !== ex) begin
            errors++;
            $display("FAIL %s: sel %0d priv %0d got %h expected %h", tag, s, p, rdata, ex);
        end
    endtask

    initial begin
        #(100_000 * 10);
        errors++;
        $display("FAIL watchdog: run did not end (got timeout, expected completion)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        rd_chk(2'd0, S_MAX, 32'd0,  "R6 U max");
        rd_chk(2'd0, S_CUR, 32'd0,  "R6 U len");
        rd_chk(2'd0, S_SUB, 32'd1,  "R6 U sub");
        rd_chk(2'd0, S_PK,  32'd0,  "R6 U packed");
        rd_chk(2'd0, S_CFG, 32'h18, "R6 U cfg");
        rd_chk(2'd1, S_CFG, 32'h08, "R6 S cfg");
        rd_chk(2'd3, S_CFG, 32'h08, "R6 M cfg");
        rd_chk(2'd3, S_MSH, 32'd0,  "R6 M shadow");
        rd_chk(2'd3, S_SSH, 32'd0,  "R6 S shadow");

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].pv, VECS[i].ws, VECS[i].wd);
            rd_chk(VECS[i].pv, VECS[i].rs, VECS[i].ex,
                   $sformatf("R%0d vector %0d", VECS[i].rq, i));
        end

        // R8: trap to S while the U bank length is rewritten
        @(negedge clk);
        priv = 2'd0; sel = S_CUR; wdata = 32'd0; we = 1'b1;
        trap_valid = 1'b1; trap_to_m = 1'b0;
        @(negedge clk);
        we = 1'b0; trap_valid = 1'b0;
        rd_chk(2'd0, S_SSH, 32'h05085245, "R8 S snapshot pre-write");
        rd_chk(2'd0, S_CUR, 32'd1,        "R8 length write lands");

        // R8: trap to M collides with a direct M shadow write
        @(negedge clk);
        priv = 2'd0; sel = S_MSH; wdata = 32'h0000AAAA; we = 1'b1;
        trap_valid = 1'b1; trap_to_m = 1'b1;
        @(negedge clk);
        we = 1'b0; trap_valid = 1'b0;
        rd_chk(2'd0, S_MSH, 32'h05085240, "R8 trap beats write");

        // R8 with R10: trap from M snapshots the M bank
        @(negedge clk);
        priv = 2'd3; trap_valid = 1'b1; trap_to_m = 1'b0;
        @(negedge clk);
        trap_valid = 1'b0;
        rd_chk(2'd3, S_SSH, 32'h03000000, "R8 M bank snapshot");
        rd_chk(2'd3, S_MSH, 32'h05085240, "R9 M shadow held");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule